// File: doc/BRIEF.md
# Dynamic Warp Regrouping Unit

This unit takes the branch-outcome masks of several warps that have reached the same branch. It repacks the threads that took the branch into as few warps as possible. A thread stays in its SIMD lane: a taken thread may move to a different warp, but only into the same lane position. Two taken threads that share a lane can therefore never end up in the same warp. The unit also reports how many regrouped warps still hold taken threads, and how many taken threads there are in total. From these two counts the SIMD utilisation of the taken path follows.

A start pulse captures the input masks. The unit then works through one lane per clock cycle. In each lane it places that lane's taken threads into the lowest-numbered output warps, then pulses done. The results stay on the outputs until the next accepted start.

Top module: `warp_regroup`

## Requirements
- R1: After reset, busy and done are 0, and mask_out, warp_count and taken_count are all zero.
- R2: Bit w*LANES+j of mask_in and of mask_out stands for warp w, lane j. A 1 means the branch was taken and a 0 means not taken.
- R3: No thread changes lane. For every lane j, the number of set bits in lane j of mask_out equals the number in lane j of mask_in.
- R4: Packing is greedy per lane. If lane j holds k taken threads, output warps 0 to k-1 have lane j set and all higher warps have it clear.
- R5: warp_count equals the number of output warps with at least one bit set. This is the largest per-lane taken count.
- R6: taken_count equals the total number of set bits in mask_in.
- R7: Let a start be sampled at clock edge E0. Then busy is 1 from edge E0 until edge E(LANES), and done is high for exactly one cycle after edge E(LANES).
- R8: A start that arrives while busy is ignored and does not alter the result. After done, the outputs hold their values while mask_in changes, until the next accepted start.
- R9: Take masks where warp 0 has lanes 31 and 1 set, warp 1 has lanes 31 and 0 set, and warp 2 has lane 30 set. The unit then empties warp 2 completely and reports warp_count 2 and taken_count 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a regrouping when the unit is idle |
| mask_in | input | WARPS*LANES | Taken masks of the input warps |
| busy | output | 1 | High while lanes are being processed |
| done | output | 1 | One-cycle pulse when the results are ready |
| mask_out | output | WARPS*LANES | Regrouped taken masks |
| warp_count | output | $clog2(WARPS+1) | Number of non-empty output warps |
| taken_count | output | $clog2(WARPS*LANES+1) | Total number of taken threads |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of a pass, while the captured masks are still being consumed. The bench raises start with the inverted mask several cycles into a run. It then confirms that the result matches the first mask and that done still arrives on time. Lanes with every warp taken, and lanes in which only the highest warp is taken, also need deliberate stimulus. For these, random masks are built with different densities by AND-ing and OR-ing several random words, alongside the directed all-ones, all-zeros and single-warp cases.

// File: rtl/warp_regroup.sv
module warp_regroup #(
  parameter int LANES = 32,
  parameter int WARPS = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [WARPS*LANES-1:0]               mask_in,
  output logic                                 busy,
  output logic                                 done,
  output logic [WARPS*LANES-1:0]               mask_out,
  output logic [$clog2(WARPS+1)-1:0]           warp_count,
  output logic [$clog2(WARPS*LANES+1)-1:0]     taken_count
);
  localparam int LW = $clog2(LANES);
  localparam int CW = $clog2(WARPS+1);
  localparam int TW = $clog2(WARPS*LANES+1);

  logic [WARPS-1:0][LANES-1:0] src, res;
  logic [LW-1:0]               idx;
  logic [WARPS-1:0]            col;
  logic [CW-1:0]               hits, wcnt;
  logic [TW-1:0]               tcnt;
  logic                        last;

  always_comb begin
    for (int w = 0; w < WARPS; w++) col[w] = src[w][idx];
  end

  assign hits = CW'($countones(col));
  assign last = (idx == LW'(LANES-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= '0;
      res  <= '0;
      idx  <= '0;
      wcnt <= '0;
      tcnt <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          src  <= mask_in;
          res  <= '0;
          idx  <= '0;
          wcnt <= '0;
          tcnt <= '0;
          busy <= 1'b1;
        end
      end else begin
        for (int w = 0; w < WARPS; w++) res[w][idx] <= (int'(hits) > w);
        tcnt <= tcnt + TW'(hits);
        if (hits > wcnt) wcnt <= hits;
        idx <= idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign mask_out    = res;
  assign warp_count  = wcnt;
  assign taken_count = tcnt;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(src));
  assert_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tcnt == TW'($countones(res))));
  assert_warps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((wcnt == '0) == (res[0] == '0)) && (int'(wcnt) <= WARPS));

  for (genvar g = 1; g < WARPS; g++) begin : g_compact
    assert_compact_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (res[g] != '0)) |-> (res[g-1] != '0));
  end
endmodule

// File: tb/warp_regroup_tb.sv
module warp_regroup_tb;
  localparam int LANES = 32;
  localparam int WARPS = 3;
  localparam int MW = WARPS*LANES;

  logic clk = 0, rst_n = 0, start = 0;
  logic [MW-1:0] mask_in = '0;
  logic busy, done;
  logic [MW-1:0] mask_out;
  logic [1:0] warp_count;
  logic [6:0] taken_count;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  warp_regroup #(.LANES(LANES), .WARPS(WARPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_in(mask_in),
    .busy(busy), .done(done), .mask_out(mask_out),
    .warp_count(warp_count), .taken_count(taken_count));

  function automatic logic [MW-1:0] ref_pack(input logic [MW-1:0] m);
    logic [MW-1:0] r = '0;
    for (int j = 0; j < LANES; j++) begin
      int k = 0;
      for (int w = 0; w < WARPS; w++) k += int'(m[w*LANES+j]);
      for (int w = 0; w < k; w++) r[w*LANES+j] = 1'b1;
    end
    return r;
  endfunction

  function automatic int ref_warps(input logic [MW-1:0] m);
    int best = 0;
    for (int j = 0; j < LANES; j++) begin
      int k = 0;
      for (int w = 0; w < WARPS; w++) k += int'(m[w*LANES+j]);
      if (k > best) best = k;
    end
    return best;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [MW-1:0] m, input bit mid);
    int cyc;
    logic [MW-1:0] held;
    @(negedge clk); mask_in = m; start = 1;
    @(negedge clk); start = 0; cyc = 1;
    while (!done && cyc < 200) begin
      if (mid && cyc == 5) begin start = 1; mask_in = ~m; end
      else start = 0;
      @(negedge clk); cyc++;
    end
    start = 0;
    check(cyc == LANES+1, "R7 latency", 128'(cyc), 128'(LANES+1));
    check(mask_out == ref_pack(m), mid ? "R8 start ignored" : "R3 R4 lane packing",
          128'(mask_out), 128'(ref_pack(m)));
    check(int'(warp_count) == ref_warps(m), "R5 warp_count", 128'(warp_count), 128'(ref_warps(m)));
    check(int'(taken_count) == $countones(m), "R6 taken_count", 128'(taken_count), 128'($countones(m)));
    held = mask_out;
    mask_in = {$urandom, $urandom, $urandom};
    @(negedge clk);
    check(!done, "R7 done single pulse", 128'(done), 128'(0));
    @(negedge clk); @(negedge clk);
    check(mask_out == held && !busy, "R8 hold", 128'(mask_out), 128'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [MW-1:0] ex;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && mask_out == '0 && warp_count == 0 && taken_count == 0,
          "R1 reset", 128'(mask_out), 128'(0));
    rst_n = 1;
    ex = '0;
    ex[0*LANES+31] = 1; ex[0*LANES+1] = 1;
    ex[1*LANES+31] = 1; ex[1*LANES+0] = 1;
    ex[2*LANES+30] = 1;
    run_case(ex, 0);
    check(mask_out[2*LANES +: LANES] == '0 && warp_count == 2 && taken_count == 5,
          "R9 example empties warp 2", 128'(mask_out), 128'(ref_pack(ex)));
    check(mask_out[0*LANES +: LANES] == 32'hC000_0003, "R2 R4 warp 0 layout",
          128'(mask_out[0 +: LANES]), 128'h C000_0003);
    run_case('0, 0);
    run_case('1, 0);
    run_case({32'hFFFF_FFFF, 64'h0}, 0);
    run_case({32'h8000_0001, 32'h0, 32'h0}, 0);
    run_case({$urandom, $urandom, $urandom}, 1);
    for (int i = 0; i < 40; i++) begin
      logic [MW-1:0] a, b;
      a = {$urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom};
      case (i % 3)
        0: run_case(a & b, 0);
        1: run_case(a | b, i == 10);
        default: run_case(a, 0);
      endcase
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule